// File: doc/BRIEF.md
# JTAG Transparent Port Bridge Controller

This block links a backplane JTAG port to one of several local scan ports, so that a tester on the backplane can reach the chain behind that local port as if it were wired straight through. The TAP controller and the instruction decoder sit outside the block. It sees the current backplane TAP state as a 4-bit code and the decoded instruction register value. A transparent instruction names a local port. When it is loaded through Update-IR, the block arms that port. The port's reset stays released and its mode-select is pulled low, so the targets behind it settle in Run-Test/Idle. When the backplane TAP next reaches Run-Test/Idle, the port goes live. Its clock, mode-select, reset and data outputs then mirror the backplane, and the backplane data output returns that port's data input.

The connection is sticky. Once armed, only a backplane TRST assertion or a power-on reset clears it. Walking the TAP into Test-Logic-Reset does not clear it, and neither do further instructions of any kind. Ports that are not bridged are held in Test-Logic-Reset with their mode-select high. Their clocks run for a fixed number of backplane clocks and then stop.

Top module: `jtag_bridge_ctrl`

## Requirements
- R1: While por_n_i or bp_trst_n_i is low, the block is unarmed. Every port then drives lp_tms_o high and lp_tdo_o low, and lp_oe_o, bp_oe_o and bp_tdo_o are low. After both inputs are high, the third rising tck_i edge is the first one that can change the mode.
- R2: The port is armed by a rising tck_i edge at which tap_state_i is Update-IR (4'hD) and ir_code_i is 8'h28+n with n below 8. The bridged port is n. While the port is armed, its lp_tms_o is low and its lp_trst_n_o is high. The same code presented in any other state, including Update-DR (4'h5), does not arm. Other codes in Update-IR do not arm.
- R3: An armed port stays armed through every TAP state until the first rising edge at which tap_state_i is Run-Test/Idle (4'hC). After that edge the port is live: its lp_tms_o equals bp_tms_i, its lp_trst_n_o equals bp_trst_n_i and its lp_tdo_o equals bp_tdi_i. bp_tdo_o equals that port's lp_tdi_i bit.
- R4: bp_oe_o and the bridged port's lp_oe_o are high only while the port is live and tap_state_i is Shift-DR (4'h2) or Shift-IR (4'hA). The lp_oe_o of every other port is always low.
- R5: Every port that is not bridged drives lp_tms_o high and lp_tdo_o low, and its lp_trst_n_o equals bp_trst_n_i.
- R6: A cycle counter starts from zero at reset release and restarts from zero at the arming edge. It stops at 512. The local clock of a port that is not bridged pulses with tck_i until the counter reaches 512, and from the following falling edge it is held low. The bridged port's clock pulses with tck_i while the port is armed or live.
- R7: Once armed, the block stays armed or live, however many cycles tap_state_i spends in Test-Logic-Reset (4'hF). Only R1's resets leave the mode.
- R8: While armed or live, every code presented at Update-IR has no effect on which port is bridged. This includes soft-reset (8'h0E), go-to-wait (8'h0F) and the other transparent codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Backplane test clock |
| bp_trst_n_i | input | 1 | Backplane test reset, active low |
| por_n_i | input | 1 | Power-on reset, active low |
| tap_state_i | input | 4 | Current backplane TAP state code |
| ir_code_i | input | 8 | Decoded instruction register value |
| bp_tms_i | input | 1 | Backplane mode-select |
| bp_tdi_i | input | 1 | Backplane data in |
| bp_tdo_o | output | 1 | Backplane data out |
| bp_oe_o | output | 1 | Backplane data-out drive enable |
| lp_tdi_i | input | 8 | Data returned by each local port |
| lp_tck_o | output | 8 | Gated local clocks |
| lp_tms_o | output | 8 | Local mode-select per port |
| lp_trst_n_o | output | 8 | Local test reset per port, active low |
| lp_tdo_o | output | 8 | Local data out per port |
| lp_oe_o | output | 8 | Local drive enable per port |

## Verification
The bench presents the transparent code in Update-DR and in Shift-IR. A controller that decoded the instruction in any state would arm on these. It then routes the armed TAP through Shift-DR before Run-Test/Idle, so a design that went live straight at Update-IR would pass data and raise the enables too early. While the port is live, the bench issues soft-reset, go-to-wait and another port's code, then holds Test-Logic-Reset for several cycles. A design that reacted to any of these would switch ports or drop the bridge. The bench runs more than 512 idle cycles and then arms a port. This catches a gating counter that is off by one, one that wraps instead of stopping, and one that is not restarted when a port is armed.

// File: rtl/jtb_pkg.sv
package jtb_pkg;
  typedef enum logic [3:0] {
    TS_EXIT2_DR = 4'h0, TS_EXIT1_DR = 4'h1, TS_SHIFT_DR = 4'h2, TS_PAUSE_DR = 4'h3,
    TS_SEL_IR   = 4'h4, TS_UPD_DR   = 4'h5, TS_CAP_DR   = 4'h6, TS_SEL_DR   = 4'h7,
    TS_EXIT2_IR = 4'h8, TS_EXIT1_IR = 4'h9, TS_SHIFT_IR = 4'hA, TS_PAUSE_IR = 4'hB,
    TS_RTI      = 4'hC, TS_UPD_IR   = 4'hD, TS_CAP_IR   = 4'hE, TS_TLR      = 4'hF
  } tap_state_e;

  typedef enum logic [1:0] {
    MD_OFF   = 2'd0,
    MD_ARMED = 2'd1,
    MD_LIVE  = 2'd2
  } bridge_mode_e;
endpackage

// File: rtl/jtb_rst_sync.sv
module jtb_rst_sync (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/jtb_mode_fsm.sv
module jtb_mode_fsm
  import jtb_pkg::*;
#(
  parameter int          NPORTS      = 8,
  parameter int          IR_W        = 8,
  parameter logic [7:0]  XP_BASE     = 8'h28,
  parameter int          GATE_CYCLES = 512,
  localparam int         SEL_W       = $clog2(NPORTS),
  localparam int         CNT_W       = $clog2(GATE_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  tap_state_e       tap_i,
  input  logic [IR_W-1:0]  ir_code_i,
  output bridge_mode_e     mode_o,
  output logic [SEL_W-1:0] sel_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             park_run_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(GATE_CYCLES);

  bridge_mode_e     mode_q, mode_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             code_hit;

  assign code_hit = (ir_code_i[IR_W-1:SEL_W] == XP_BASE[IR_W-1:SEL_W]) &&
                    (32'(ir_code_i[SEL_W-1:0]) < NPORTS);

  always_comb begin
    mode_d = mode_q;
    sel_d  = sel_q;
    cnt_d  = (cnt_q == LIMIT) ? cnt_q : cnt_q + 1'b1;
    unique case (mode_q)
      MD_OFF: begin
        if (tap_i == TS_UPD_IR && code_hit) begin
          mode_d = MD_ARMED;
          sel_d  = ir_code_i[SEL_W-1:0];
          cnt_d  = '0;
        end
      end
      MD_ARMED: if (tap_i == TS_RTI) mode_d = MD_LIVE;
      default:  mode_d = MD_LIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      mode_q <= MD_OFF;
      sel_q  <= '0;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      sel_q  <= sel_d;
      cnt_q  <= cnt_d;
    end
  end

  assign mode_o     = mode_q;
  assign sel_o      = sel_q;
  assign cnt_o      = cnt_q;
  assign park_run_o = (cnt_q < LIMIT);
endmodule

// File: rtl/jtb_port_slice.sv
module jtb_port_slice (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic is_sel_i,
  input  logic armed_i,
  input  logic live_i,
  input  logic park_run_i,
  input  logic shift_i,
  input  logic bp_tms_i,
  input  logic bp_trst_n_i,
  input  logic bp_tdi_i,
  output logic tck_o,
  output logic tms_o,
  output logic trst_n_o,
  output logic tdo_o,
  output logic oe_o
);
  logic clk_en_d, clk_en_q;

  assign clk_en_d = (is_sel_i && (armed_i || live_i)) || park_run_i;

  always_ff @(negedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) clk_en_q <= 1'b1;
    else          clk_en_q <= clk_en_d;
  end

  assign tck_o = clk_i & clk_en_q;

  always_comb begin
    tms_o    = 1'b1;
    trst_n_o = bp_trst_n_i;
    tdo_o    = 1'b0;
    oe_o     = 1'b0;
    if (is_sel_i && armed_i) begin
      tms_o    = 1'b0;
      trst_n_o = 1'b1;
    end else if (is_sel_i && live_i) begin
      tms_o = bp_tms_i;
      tdo_o = bp_tdi_i;
      oe_o  = shift_i;
    end
  end
endmodule

// File: rtl/jtag_bridge_ctrl.sv
module jtag_bridge_ctrl
  import jtb_pkg::*;
#(
  parameter int         NPORTS      = 8,
  parameter int         IR_W        = 8,
  parameter logic [7:0] XP_BASE     = 8'h28,
  parameter int         GATE_CYCLES = 512,
  localparam int        SEL_W       = $clog2(NPORTS),
  localparam int        CNT_W       = $clog2(GATE_CYCLES + 1)
) (
  input  logic              tck_i,
  input  logic              bp_trst_n_i,
  input  logic              por_n_i,
  input  logic [3:0]        tap_state_i,
  input  logic [IR_W-1:0]   ir_code_i,
  input  logic              bp_tms_i,
  input  logic              bp_tdi_i,
  output logic              bp_tdo_o,
  output logic              bp_oe_o,
  input  logic [NPORTS-1:0] lp_tdi_i,
  output logic [NPORTS-1:0] lp_tck_o,
  output logic [NPORTS-1:0] lp_tms_o,
  output logic [NPORTS-1:0] lp_trst_n_o,
  output logic [NPORTS-1:0] lp_tdo_o,
  output logic [NPORTS-1:0] lp_oe_o
);
  tap_state_e       tap;
  bridge_mode_e     mode;
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] gate_cnt;
  logic             core_rst_n, park_run, shift, armed, live;

  assign tap   = tap_state_e'(tap_state_i);
  assign shift = (tap == TS_SHIFT_DR) || (tap == TS_SHIFT_IR);
  assign armed = (mode == MD_ARMED);
  assign live  = (mode == MD_LIVE);

  jtb_rst_sync u_rst (
    .clk_i    (tck_i),
    .arst_n_i (bp_trst_n_i & por_n_i),
    .rst_n_o  (core_rst_n)
  );

  jtb_mode_fsm #(
    .NPORTS(NPORTS), .IR_W(IR_W), .XP_BASE(XP_BASE), .GATE_CYCLES(GATE_CYCLES)
  ) u_fsm (
    .clk_i      (tck_i),
    .rst_n_i    (core_rst_n),
    .tap_i      (tap),
    .ir_code_i  (ir_code_i),
    .mode_o     (mode),
    .sel_o      (sel),
    .cnt_o      (gate_cnt),
    .park_run_o (park_run)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    jtb_port_slice u_slice (
      .clk_i       (tck_i),
      .rst_n_i     (core_rst_n),
      .is_sel_i    (32'(sel) == p),
      .armed_i     (armed),
      .live_i      (live),
      .park_run_i  (park_run),
      .shift_i     (shift),
      .bp_tms_i    (bp_tms_i),
      .bp_trst_n_i (bp_trst_n_i),
      .bp_tdi_i    (bp_tdi_i),
      .tck_o       (lp_tck_o[p]),
      .tms_o       (lp_tms_o[p]),
      .trst_n_o    (lp_trst_n_o[p]),
      .tdo_o       (lp_tdo_o[p]),
      .oe_o        (lp_oe_o[p])
    );
  end

  assign bp_tdo_o = live ? lp_tdi_i[sel] : 1'b0;
  assign bp_oe_o  = live & shift;
endmodule

// File: rtl/jtb_bridge_chk.sv
module jtb_bridge_chk
  import jtb_pkg::*;
#(
  parameter int  NPORTS      = 8,
  parameter int  GATE_CYCLES = 512,
  localparam int SEL_W       = $clog2(NPORTS),
  localparam int CNT_W       = $clog2(GATE_CYCLES + 1)
) (
  input logic              clk_i,
  input logic              rst_n_i,
  input logic [3:0]        tap_i,
  input bridge_mode_e      mode_i,
  input logic [SEL_W-1:0]  sel_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              bp_oe_i,
  input logic              bp_tdo_i,
  input logic [NPORTS-1:0] lp_oe_i,
  input logic [NPORTS-1:0] lp_tdi_i
);
  // R4
  bp_oe_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !(tap_i == TS_SHIFT_DR || tap_i == TS_SHIFT_IR) |-> !bp_oe_i);

  // R4
  lp_oe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $onehot0(lp_oe_i));

  // R7
  mode_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (mode_i != MD_OFF) |=> (mode_i != MD_OFF));

  // R8
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (mode_i != MD_OFF) |=> $stable(sel_i));

  // R6
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    32'(cnt_i) <= GATE_CYCLES);

  // R3
  tdo_return_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (mode_i == MD_LIVE) |-> (bp_tdo_i == lp_tdi_i[sel_i]));
endmodule

bind jtag_bridge_ctrl jtb_bridge_chk #(
  .NPORTS(NPORTS), .GATE_CYCLES(GATE_CYCLES)
) u_chk (
  .clk_i    (tck_i),
  .rst_n_i  (core_rst_n),
  .tap_i    (tap_state_i),
  .mode_i   (mode),
  .sel_i    (sel),
  .cnt_i    (gate_cnt),
  .bp_oe_i  (bp_oe_o),
  .bp_tdo_i (bp_tdo_o),
  .lp_oe_i  (lp_oe_o),
  .lp_tdi_i (lp_tdi_i)
);

// File: tb/test_jtag_bridge_ctrl.sv
module test_jtag_bridge_ctrl;
  localparam int CLK_P = 10;
  localparam int NP    = 8;
  localparam int GATE  = 512;

  logic           tck, bp_trst_n, por_n, bp_tms, bp_tdi;
  logic [3:0]     tap;
  logic [7:0]     ir;
  logic [NP-1:0]  lp_tdi;
  logic           bp_tdo, bp_oe;
  logic [NP-1:0]  lp_tck, lp_tms, lp_trst_n, lp_tdo, lp_oe;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_mode = 0, m_sel = 0, m_cnt = 0, m_hold = 0;
  logic [NP-1:0] m_en = '1;
  string phase = "R1";
  bit done = 0;

  jtag_bridge_ctrl i_jtag_bridge_ctrl (
    .tck_i(tck), .bp_trst_n_i(bp_trst_n), .por_n_i(por_n), .tap_state_i(tap),
    .ir_code_i(ir), .bp_tms_i(bp_tms), .bp_tdi_i(bp_tdi), .bp_tdo_o(bp_tdo),
    .bp_oe_o(bp_oe), .lp_tdi_i(lp_tdi), .lp_tck_o(lp_tck), .lp_tms_o(lp_tms),
    .lp_trst_n_o(lp_trst_n), .lp_tdo_o(lp_tdo), .lp_oe_o(lp_oe)
  );

  initial tck = 1'b0;
  always #(CLK_P/2) tck = ~tck;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] cyc %0d %s: actual %b expected %b", tag, phase, cyc, what, act, exp);
    end
  endtask

  function automatic string mode_tag(input bit sel_p);
    if (!sel_p) return (m_mode == 0) ? "R1" : "R5";
    return (m_mode == 1) ? "R2" : "R3";
  endfunction

  task automatic compare_all();
    bit sh;
    sh = (tap == 4'h2) || (tap == 4'hA);
    for (int p = 0; p < NP; p++) begin
      bit sp;
      logic e_tms, e_trst, e_tdo, e_oe;
      sp     = (m_mode != 0) && (m_sel == p);
      e_tms  = (sp && m_mode == 2) ? bp_tms : ((sp && m_mode == 1) ? 1'b0 : 1'b1);
      e_trst = (sp && m_mode == 1) ? 1'b1 : bp_trst_n;
      e_tdo  = (sp && m_mode == 2) ? bp_tdi : 1'b0;
      e_oe   = sp && m_mode == 2 && sh;
      chk(mode_tag(sp), $sformatf("lp_tms[%0d]", p), lp_tms[p], e_tms);
      chk(mode_tag(sp), $sformatf("lp_trst_n[%0d]", p), lp_trst_n[p], e_trst);
      chk(mode_tag(sp), $sformatf("lp_tdo[%0d]", p), lp_tdo[p], e_tdo);
      chk("R4", $sformatf("lp_oe[%0d]", p), lp_oe[p], e_oe);
      chk("R6", $sformatf("lp_tck[%0d]", p), lp_tck[p], m_en[p]);
    end
    chk("R3", "bp_tdo", bp_tdo, (m_mode == 2) ? lp_tdi[m_sel] : 1'b0);
    chk("R4", "bp_oe", bp_oe, (m_mode == 2) && sh);
  endtask

  task automatic model_edge();
    if (!(por_n && bp_trst_n)) begin
      m_mode = 0; m_sel = 0; m_cnt = 0; m_hold = 0;
    end else if (m_hold < 2) begin
      m_mode = 0; m_sel = 0; m_cnt = 0; m_hold++;
    end else if (m_mode == 0 && tap == 4'hD && ir[7:3] == 5'b00101) begin
      m_mode = 1; m_sel = int'(ir[2:0]); m_cnt = 0;
    end else begin
      if (m_mode == 1 && tap == 4'hC) m_mode = 2;
      if (m_cnt < GATE) m_cnt++;
    end
  endtask

  task automatic step(input logic [3:0] ts, input logic [7:0] code, input logic tms, input logic tdi);
    @(negedge tck);
    tap = ts; ir = code; bp_tms = tms; bp_tdi = tdi;
    lp_tdi = 8'(cyc * 37 + 5);
    cyc++;
    if (!(por_n && bp_trst_n)) begin
      m_mode = 0; m_sel = 0; m_cnt = 0; m_hold = 0;
    end
    for (int p = 0; p < NP; p++)
      m_en[p] = (m_hold < 2) || (m_mode != 0 && m_sel == p) || (m_cnt < GATE);
    @(posedge tck);
    model_edge();
    #2;
    compare_all();
  endtask

  task automatic idle(input int n, input logic [3:0] ts);
    for (int i = 0; i < n; i++) step(ts, 8'h00, 1'b0, i[0]);
  endtask

  task automatic shift_burst(input logic [3:0] ts, input int n);
    for (int i = 0; i < n; i++) step(ts, 8'h00, i[1], i[0] ^ i[2]);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; bp_trst_n = 1'b1; tap = 4'hF; ir = 8'h00;
    bp_tms = 1'b1; bp_tdi = 1'b0; lp_tdi = '0;
    // R1: power-on reset holds everything parked
    phase = "R1";
    idle(3, 4'hF);
    por_n = 1'b1;
    idle(4, 4'hC);
    // R2: wrong state or wrong code must not arm
    phase = "R2";
    step(4'h5, 8'h2B, 1'b0, 1'b1);
    step(4'hA, 8'h2B, 1'b0, 1'b1);
    step(4'hD, 8'h15, 1'b0, 1'b1);
    step(4'hD, 8'h0E, 1'b0, 1'b1);
    // R2: arm port 3, then R3: route through Shift-DR before Run-Test/Idle
    step(4'hD, 8'h2B, 1'b1, 1'b0);
    phase = "R3";
    step(4'h7, 8'h00, 1'b0, 1'b1);
    step(4'h6, 8'h00, 1'b0, 1'b1);
    shift_burst(4'h2, 3);
    step(4'h1, 8'h00, 1'b1, 1'b0);
    step(4'h5, 8'h00, 1'b0, 1'b0);
    step(4'hC, 8'h00, 1'b0, 1'b1);
    // R4: live shifting in both shift states
    phase = "R4";
    shift_burst(4'h2, 12);
    shift_burst(4'hB, 3);
    shift_burst(4'hA, 10);
    // R8: further instructions ignored
    phase = "R8";
    step(4'hD, 8'h2D, 1'b1, 1'b0);
    step(4'hD, 8'h0E, 1'b0, 1'b1);
    step(4'hD, 8'h0F, 1'b1, 1'b1);
    shift_burst(4'h2, 4);
    // R7: long stay in Test-Logic-Reset does not clear the bridge
    phase = "R7";
    for (int i = 0; i < 8; i++) step(4'hF, 8'h00, 1'b1, i[0]);
    shift_burst(4'h2, 4);
    // R6: unselected clocks stop after the limit, bridged clock keeps running
    phase = "R6";
    idle(GATE + 8, 4'hC);
    // R1: backplane TRST leaves the mode
    phase = "R1";
    bp_trst_n = 1'b0;
    idle(3, 4'hC);
    bp_trst_n = 1'b1;
    idle(4, 4'hC);
    // R6: idle gating from reset release, then arming restarts the counter
    phase = "R6";
    idle(GATE + 6, 4'hC);
    step(4'hD, 8'h2F, 1'b0, 1'b0);
    phase = "R8";
    step(4'hB, 8'h00, 1'b0, 1'b0);
    step(4'h8, 8'h00, 1'b1, 1'b0);
    step(4'hD, 8'h28, 1'b1, 1'b0);
    step(4'hC, 8'h00, 1'b0, 1'b1);
    phase = "R3";
    shift_burst(4'h2, 10);
    // R1: power-on reset while live
    phase = "R1";
    por_n = 1'b0;
    idle(3, 4'h2);
    por_n = 1'b1;
    idle(3, 4'hC);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule